// File: doc/BRIEF.md
# NAND flash bus cycle generator

This block sits between a byte-wide register port and the pins of a NAND flash device. A single-byte write to the command slot produces one bus cycle with the command latch enable high. A write to the address slot produces one with the address latch enable high. A write to the data slot produces a plain data write cycle. A read of the data slot produces a read cycle, and the byte returned by the device is kept in a read buffer. Every bus cycle has three phases: setup, strobe active and hold. Each phase length is programmable and is held in its register as the cycle count minus one.

Software first writes the timing registers and clears the chip-enable-off bit. It then issues command, address and data accesses. While a cycle runs, the block stalls any further write and any data-slot read. Status reads pass without stall and show the synchronized ready/busy pin and the busy flag. The parameter `WIDE_SETUP` chooses between a 2-bit setup field (1 to 4 cycles) and a 3-bit one (1 to 8 cycles).

Top module: `nand_cycle_gen`

## Requirements
- R1: After reset, chip enable is deasserted (`nf_ce_n`=1), both latch enables are 0, both strobes are 1, the bus is not driven, and `stall` is 0. The timing register (slot 1) reads 0x3F and the setup register (slot 2) reads all ones of its field width (0x03 by default).
- R2: A write to slot 4 launches a cycle in which `nf_cle` is 1 and `nf_ale` is 0 in every cycle. The written byte is on `nf_io_out` when `nf_we_n` rises.
- R3: A write to slot 5 launches a cycle in which `nf_ale` is 1 and `nf_cle` is 0 in every cycle. The latch enables are never both 1.
- R4: The setup phase lasts setup-field+1 clocks. It runs from the cycle after the access is accepted up to the strobe.
- R5: The strobe is low for bits [2:0] of slot 1, plus 1, clocks.
- R6: The hold phase lasts bits [5:3] of slot 1, plus 1, clocks. It runs after the strobe and ends when the busy state ends.
- R7: The setup field is bits [1:0] of slot 2 when `WIDE_SETUP`=0 and bits [2:0] when it is 1. Higher written bits are ignored and read back as 0.
- R8: Bit 0 of slot 0 drives `nf_ce_n` directly. Writing 1 deasserts chip enable, and reset leaves it at 1.
- R9: Slot 3 reads the ready pin in bit 0, through a two-flop synchronizer (1 = ready), and the busy flag in bit 1.
- R10: While a cycle runs, `stall` is 1 for any write request and for any slot-6 read request, and the request takes no effect. It is accepted on the first clock after the hold phase ends.
- R11: In write cycles, `nf_io_oe` is 1 from the first setup clock to the last hold clock, and `nf_io_out` stays constant. In read cycles, `nf_io_oe` stays 0.
- R12: A slot-6 read launches a cycle that pulses `nf_re_n` instead of `nf_we_n`. The value on `nf_io_in` during the last strobe clock is captured and read back from slot 7.
- R13: A timing write made stalled during a cycle does not alter that cycle. It takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request (launches a cycle only for slot 6) |
| reg_addr | input | 3 | Register slot |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte for the addressed slot |
| stall | output | 1 | Request held off while a cycle runs |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Byte driven to the device |
| nf_io_oe | output | 1 | Output enable for the I/O bus |
| nf_io_in | input | 8 | Byte returned by the device |
| nf_ready | input | 1 | Device ready/busy pin, 1 = ready |

## Verification
The bench measures each phase length by counting sampled clocks. It does so with all phase fields at their minimum, at mixed values and at the clipped setup maximum. A counter that is off by one, or that loads the wrong field, therefore shows up as a wrong count.

A small device model is used for reads. It returns a byte that changes with every strobe clock, so capturing one clock early or late gives a different buffered value. The model also drives the bus only from the device side.

A timing write is issued in the middle of a long cycle. The bench counts the stall clocks and checks that the running strobe still uses the old width. A design that let the write through would shorten the live cycle or lose the write.

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen #(
  parameter bit WIDE_SETUP = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       stall,
  output logic       nf_ce_n,
  output logic       nf_cle,
  output logic       nf_ale,
  output logic       nf_we_n,
  output logic       nf_re_n,
  output logic [7:0] nf_io_out,
  output logic       nf_io_oe,
  input  logic [7:0] nf_io_in,
  input  logic       nf_ready
);
  localparam int SW = WIDE_SETUP ? 3 : 2;
  localparam logic [2:0] A_CTRL = 3'd0, A_TIMING = 3'd1, A_SETUP = 3'd2, A_STATUS = 3'd3,
                         A_CMD = 3'd4, A_ADDR = 3'd5, A_DATA = 3'd6, A_RDBUF = 3'd7;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_t;

  phase_t          phase;
  logic [2:0]      cnt;
  logic [SW-1:0]   setup_m1;
  logic [2:0]      width_m1, hold_m1;
  logic            ce_off, k_cle, k_ale, k_read;
  logic [7:0]      obyte, rdbuf;
  logic            rb_s1, rb_s2;

  wire busy     = (phase != PH_IDLE);
  wire wr_cycle = reg_wr && (reg_addr == A_CMD || reg_addr == A_ADDR || reg_addr == A_DATA);
  wire rd_cycle = !reg_wr && reg_rd && (reg_addr == A_DATA);
  wire launch   = !busy && (wr_cycle || rd_cycle);
  wire cfg_we   = !busy && reg_wr;

  assign stall = busy && (reg_wr || (reg_rd && reg_addr == A_DATA));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      setup_m1 <= '1;
      width_m1 <= '1;
      hold_m1  <= '1;
      ce_off   <= 1'b1;
      k_cle    <= 1'b0;
      k_ale    <= 1'b0;
      k_read   <= 1'b0;
      obyte    <= '0;
      rdbuf    <= '0;
      rb_s1    <= 1'b0;
      rb_s2    <= 1'b0;
    end else begin
      rb_s1 <= nf_ready;
      rb_s2 <= rb_s1;
      if (cfg_we) begin
        case (reg_addr)
          A_CTRL:   ce_off <= reg_wdata[0];
          A_TIMING: begin width_m1 <= reg_wdata[2:0]; hold_m1 <= reg_wdata[5:3]; end
          A_SETUP:  setup_m1 <= reg_wdata[SW-1:0];
          default:  ;
        endcase
      end
      case (phase)
        PH_IDLE: if (launch) begin
          phase  <= PH_SETUP;
          cnt    <= 3'(setup_m1);
          k_cle  <= reg_wr && reg_addr == A_CMD;
          k_ale  <= reg_wr && reg_addr == A_ADDR;
          k_read <= !reg_wr;
          obyte  <= reg_wdata;
        end
        PH_SETUP: if (cnt == 0) begin
          phase <= PH_STROBE;
          cnt   <= width_m1;
        end else cnt <= cnt - 3'd1;
        PH_STROBE: if (cnt == 0) begin
          phase <= PH_HOLD;
          cnt   <= hold_m1;
          if (k_read) rdbuf <= nf_io_in;
        end else cnt <= cnt - 3'd1;
        default: if (cnt == 0) phase <= PH_IDLE;
                 else cnt <= cnt - 3'd1;
      endcase
    end
  end

  assign nf_ce_n   = ce_off;
  assign nf_cle    = busy && k_cle;
  assign nf_ale    = busy && k_ale;
  assign nf_we_n   = !(phase == PH_STROBE && !k_read);
  assign nf_re_n   = !(phase == PH_STROBE && k_read);
  assign nf_io_oe  = busy && !k_read;
  assign nf_io_out = obyte;

  always_comb begin
    case (reg_addr)
      A_CTRL:   reg_rdata = {7'd0, ce_off};
      A_TIMING: reg_rdata = {2'd0, hold_m1, width_m1};
      A_SETUP:  reg_rdata = 8'(setup_m1);
      A_STATUS: reg_rdata = {6'd0, busy, rb_s2};
      A_RDBUF:  reg_rdata = rdbuf;
      default:  reg_rdata = 8'd0;
    endcase
  end

  logic [3:0] str_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) str_len <= '0;
    else if (phase == PH_STROBE) str_len <= str_len + 4'd1;
    else str_len <= '0;
  end

  p_strobe_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD && $past(phase) == PH_STROBE) |-> str_len == {1'b0, width_m1} + 4'd1);
  p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));
  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));
  p_no_drive_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_re_n |-> !nf_io_oe);
  p_bus_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (nf_io_oe && $past(nf_io_oe)) |-> $stable(nf_io_out));
  p_cfg_frozen_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(width_m1) && $stable(hold_m1) && $stable(setup_m1)));
endmodule

// File: tb/nand_cycle_gen_bench.sv
`timescale 1ns/1ps
module nand_cycle_gen_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, nf_io_out, nf_io_in;
  logic stall, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
  logic nf_ready = 1'b1;
  int total = 0, fails = 0;

  always #10 clk = ~clk;

  nand_cycle_gen u_nand_cycle_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stall(stall), .nf_ce_n(nf_ce_n),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in), .nf_ready(nf_ready));

  // device model: read byte varies with each strobe clock; latched writes logged
  logic [2:0] re_cnt = 0;
  always @(posedge clk) re_cnt <= nf_re_n ? 3'd0 : re_cnt + 3'd1;
  assign nf_io_in = 8'hC0 | {5'd0, re_cnt};
  logic [7:0] m_byte = 0;
  logic m_cle = 0, m_ale = 0, m_oe = 0;
  always @(posedge nf_we_n) if (rst_n) begin
    m_byte = nf_io_out; m_cle = nf_cle; m_ale = nf_ale; m_oe = nf_io_oe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [2:0] a, input logic [7:0] d, input bit rd);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = !rd; reg_rd = rd;
    #1;
    while (stall) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    reg_wr = 0; reg_rd = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_wr = 0; reg_rd = 0;
    #1 v = reg_rdata;
  endtask

  int s_n, w_n, h_n, cle_n, ale_n, oe_n, we_n_low, re_n_low;
  task automatic measure();
    s_n = 0; w_n = 0; h_n = 0; cle_n = 0; ale_n = 0; oe_n = 0; we_n_low = 0; re_n_low = 0;
    forever begin
      @(negedge clk);
      if (!u_nand_cycle_gen.stall && !(nf_cle || nf_ale || nf_io_oe || !nf_we_n || !nf_re_n) &&
          s_n + w_n + h_n > 0 && !busy_flag()) break;
      if (!busy_flag()) break;
      if (nf_cle) cle_n++;
      if (nf_ale) ale_n++;
      if (nf_io_oe) oe_n++;
      if (!nf_we_n) we_n_low++;
      if (!nf_re_n) re_n_low++;
      if (!nf_we_n || !nf_re_n) w_n++;
      else if (w_n == 0) s_n++;
      else h_n++;
    end
  endtask

  // busy is observed through the status slot
  function automatic bit busy_flag();
    return reg_addr == 3'd3 ? reg_rdata[1] : 1'b0;
  endfunction

  task automatic run_cycle(input logic [2:0] a, input logic [7:0] d, input bit rd);
    acc(a, d, rd);
    reg_addr = 3'd3;
    measure();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 ce_n", nf_ce_n, 1); check("R1 cle", nf_cle, 0); check("R1 ale", nf_ale, 0);
    check("R1 we_n", nf_we_n, 1); check("R1 re_n", nf_re_n, 1); check("R1 oe", nf_io_oe, 0);
    check("R1 stall", stall, 0);
    rd_reg(3'd1, v); check("R1 timing reset", v, 8'h3F);
    rd_reg(3'd2, v); check("R1 setup reset", v, 8'h03);
    rd_reg(3'd0, v); check("R8 ctrl reset", v, 8'h01);
  endtask

  task automatic t_ce();
    acc(3'd0, 8'h00, 0); #1 check("R8 ce asserted", nf_ce_n, 0);
    acc(3'd0, 8'h01, 0); #1 check("R8 ce deasserted", nf_ce_n, 1);
    acc(3'd0, 8'h00, 0);
  endtask

  task automatic t_cmd();
    acc(3'd1, 8'h0A, 0); acc(3'd2, 8'h01, 0);
    run_cycle(3'd4, 8'h70, 0);
    check("R4 setup len", s_n, 2); check("R5 strobe len", w_n, 3); check("R6 hold len", h_n, 2);
    check("R2 cle every clock", cle_n, 7); check("R2 no ale", ale_n, 0);
    check("R2 byte latched", m_byte, 8'h70); check("R2 cle at latch", m_cle, 1);
  endtask

  task automatic t_addr();
    acc(3'd1, 8'h00, 0); acc(3'd2, 8'h00, 0);
    run_cycle(3'd5, 8'h3C, 0);
    check("R4 min setup", s_n, 1); check("R5 min strobe", w_n, 1); check("R6 min hold", h_n, 1);
    check("R3 ale every clock", ale_n, 3); check("R3 no cle", cle_n, 0);
    check("R3 byte latched", m_byte, 8'h3C); check("R3 ale at latch", m_ale, 1);
  endtask

  task automatic t_setup_clip();
    logic [7:0] v;
    acc(3'd2, 8'hFF, 0);
    rd_reg(3'd2, v); check("R7 upper setup bits ignored", v, 8'h03);
    run_cycle(3'd6, 8'h5A, 0);
    check("R7 clipped setup len", s_n, 4);
    check("R11 oe whole write cycle", oe_n, 6);
    check("R11 data byte", m_byte, 8'h5A); check("R11 plain data cycle", {m_cle, m_ale}, 0);
  endtask

  task automatic t_read();
    logic [7:0] v;
    acc(3'd1, 8'h02, 0); acc(3'd2, 8'h00, 0);
    run_cycle(3'd6, 8'h00, 1);
    check("R12 read setup", s_n, 1); check("R12 read strobe", re_n_low, 3);
    check("R12 no write strobe", we_n_low, 0); check("R12 read hold", h_n, 1);
    check("R11 no drive on read", oe_n, 0);
    rd_reg(3'd7, v); check("R12 captured byte", v, 8'hC2);
  endtask

  task automatic t_stall();
    logic [7:0] v;
    int n = 0, wl = 0;
    acc(3'd1, 8'h3F, 0); acc(3'd2, 8'h03, 0);
    acc(3'd4, 8'h00, 0);
    @(negedge clk);
    reg_addr = 3'd1; reg_wdata = 8'h00; reg_wr = 1;
    #1;
    while (stall) begin
      n++;
      if (!nf_we_n) wl++;
      @(negedge clk); #1;
    end
    @(posedge clk); #1 reg_wr = 0;
    check("R10 stall clocks", n, 20);
    check("R13 running strobe kept old width", wl, 8);
    rd_reg(3'd1, v); check("R10 stalled write landed", v, 8'h00);
    run_cycle(3'd4, 8'hFF, 0);
    check("R13 new setup", s_n, 4); check("R13 new strobe", w_n, 1); check("R13 new hold", h_n, 1);
  endtask

  task automatic t_status();
    logic [7:0] v;
    nf_ready = 1'b0; repeat (3) @(negedge clk);
    rd_reg(3'd3, v); check("R9 busy pin", v[0], 0);
    nf_ready = 1'b1; repeat (3) @(negedge clk);
    rd_reg(3'd3, v); check("R9 ready pin", v[0], 1);
    acc(3'd4, 8'h90, 0);
    rd_reg(3'd3, v); check("R9 busy flag", v[1], 1);
    repeat (12) @(negedge clk);
    rd_reg(3'd3, v); check("R9 busy flag clear", v[1], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ce();
    t_cmd();
    t_addr();
    t_setup_clip();
    t_read();
    t_stall();
    t_status();
    $display("  [TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end
endmodule